// File: doc/BRIEF.md
# Calibrated Seconds Counter with Deferred Time Load

This core keeps wall-clock time as a 32-bit count of seconds. A divider counts cycles of a slow crystal clock. When the count reaches a programmable limit, it emits one tick, and the tick advances the seconds count. The cycle limit and an optional fractional trim come from a calibration register. The trim lengthens a share of the seconds by one cycle, so that over sixteen seconds the average period can be adjusted in steps of one sixteenth of a cycle.

Software reaches the core through a plain single-cycle register bus. A new time written by software is not applied at once. It waits in a holding register and is copied into the running count on the next tick. Writing the calibration register restarts the divider, so that this next tick lands exactly one full period after the write. Every tick sets a sticky flag. Software clears the flag by writing 1 to it, and while the flag is set it drives the interrupt pin.

A two-state machine tracks the deferred load:
- `TK_RUN`: no time is waiting. A tick adds one to the count.
- `TK_LOAD_PEND`: a written time is waiting. A tick copies that time into the count.

The machine has these named transitions:
- `ARM`: a set-time write in `TK_RUN` moves it to `TK_LOAD_PEND`.
- `COMMIT`: a tick in `TK_LOAD_PEND`, with no new write in the same cycle, moves it back to `TK_RUN`.
- `REARM`: a further write in `TK_LOAD_PEND` stays in `TK_LOAD_PEND` and replaces the waiting value.

Top module: `rtc_sec_core`

## Requirements
- R1: After reset, the current time, the set-time readback, the status register and the control register all read 0. The calibration register reads 0x198233, and `sec_irq` is low.
- R2: A read of offset 0x04 returns the last value written to offset 0x00, starting with the first read after the write. A read of offset 0x00 itself returns 0.
- R3: A value written to offset 0x00 appears at the current-time offset 0x10 only after the next tick, and the current time does not change before that tick. When several writes come before one tick, the last one is loaded.
- R4: On a tick with no time waiting to load, the current time increases by exactly one.
- R5: With bit 20 of the calibration register clear, ticks are spaced exactly (calibration bits 15:0) + 1 clock cycles apart.
- R6: A write to offset 0x08 restarts the divider. The first tick after the write comes exactly (bits 15:0) + 1 cycles after the write, even when the write falls in the middle of a second.
- R7: The calibration register at offset 0x08 keeps only bits 20:0. Bits 31:21 of the written value are dropped and read back as 0.
- R8: With bit 20 of the calibration register set and bits 19:16 holding F, the first sixteen ticks after a calibration write span exactly 16 × ((bits 15:0) + 1) + F cycles.
- R9: Bit 0 of the status register at offset 0x20 is set by every tick. It stays set until a write to offset 0x20 with bit 0 equal to 1. A write with bit 0 equal to 0 leaves it unchanged.
- R10: `sec_irq` is high exactly while the status bit is set.
- R11: Bit 31 of the control register at offset 0x40 is readable and writable. Its other bits always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-derived counting clock; also clocks the register bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data is valid on `bus_rdata` from the next edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sec_irq | output | 1 | Seconds interrupt; high while the status flag is set |

## Verification
The assertions check the following on every cycle:
- The divider count never passes its limit, and a restart zeroes it.
- Without a tick the current time holds; with a tick it either increments or takes the waiting value, depending on the machine state.
- The status flag is sticky, and every tick sets it.

The exact tick spacing after a calibration write, the sixteen-second total with the fractional trim, the masking of calibration bits and the register readback values can only be shown by the bench's timed scenarios.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int CAL_W  = 21;

    localparam logic [ADDR_W-1:0] OFS_SET_WR  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_SET_RD  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CAL     = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_NOW     = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_CONTROL = 8'h40;

    localparam logic [CAL_W-1:0] CAL_RESET = 21'h198233;

    typedef enum logic {
        TK_RUN,
        TK_LOAD_PEND
    } tk_state_e;

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
    parameter int CNT_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [CNT_W-1:0]  cnt_max,
    input  logic [FRAC_W-1:0] frac,
    input  logic              frac_en,
    output logic              tick
);

    localparam int LIM_W = CNT_W + 1;

    logic [LIM_W-1:0]  cnt_q;
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   acc_sum;
    logic              extra;
    logic [LIM_W-1:0]  limit;

    // The carry of this second's accumulation lengthens this same second.
    assign acc_sum = {1'b0, acc_q} + {1'b0, frac};
    assign extra   = frac_en & acc_sum[FRAC_W];
    assign limit   = {1'b0, cnt_max} + LIM_W'(extra);
    assign tick    = !restart && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
            if (frac_en) begin
                acc_q <= acc_sum[FRAC_W-1:0];
            end
        end else begin
            cnt_q <= cnt_q + LIM_W'(1);
        end
    end

    // R5: the cycle count never runs beyond the longest allowed second
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= {1'b0, cnt_max} + LIM_W'(1));

    // R6: a calibration write restarts the count
    a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_time_keeper.sv
module rtc_time_keeper
    import rtc_pkg::*;
#(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              set_wr,
    input  logic [TIME_W-1:0] set_data,
    output logic [TIME_W-1:0] cur_time,
    output logic [TIME_W-1:0] set_time
);

    tk_state_e         state_q, state_d;
    logic [TIME_W-1:0] cur_q, set_q;

    // next-state logic: ARM, COMMIT, REARM
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TK_RUN: begin
                if (set_wr) state_d = TK_LOAD_PEND;          // ARM
            end
            TK_LOAD_PEND: begin
                if (set_wr)    state_d = TK_LOAD_PEND;       // REARM
                else if (tick) state_d = TK_RUN;             // COMMIT
            end
            default: state_d = TK_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TK_RUN;
        else        state_q <= state_d;
    end

    // outputs: the holding register and the running count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
            set_q <= '0;
        end else begin
            if (set_wr) set_q <= set_data;
            if (tick) begin
                unique case (state_q)
                    TK_RUN:       cur_q <= cur_q + TIME_W'(1);
                    TK_LOAD_PEND: cur_q <= set_q;
                    default:      cur_q <= cur_q;
                endcase
            end
        end
    end

    assign cur_time = cur_q;
    assign set_time = set_q;

    // R3: the count holds between ticks
    a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cur_q));

    // R3: a tick with a waiting time loads it
    a_r3_commit_load: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state_q == TK_LOAD_PEND) |=> (cur_q == $past(set_q)));

    // R4: a tick with nothing waiting adds one
    a_r4_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state_q == TK_RUN) |=> (cur_q == $past(cur_q) + TIME_W'(1)));

endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
    import rtc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick,
    input  logic [DATA_W-1:0] cur_time,
    input  logic [DATA_W-1:0] set_time,
    output logic              set_wr,
    output logic              cal_wr,
    output logic [CNT_W-1:0]  cnt_max,
    output logic [FRAC_W-1:0] frac,
    output logic              frac_en,
    output logic              irq
);

    localparam int FRAC_LSB = CNT_W;
    localparam int EN_BIT   = CNT_W + FRAC_W;

    logic [CAL_W-1:0]  cal_q;
    logic              ctrl_q;
    logic              flag_q;
    logic              clr_wr;
    logic [DATA_W-1:0] rd_mux;

    assign set_wr = bus_wr && (bus_addr == OFS_SET_WR);
    assign cal_wr = bus_wr && (bus_addr == OFS_CAL);
    assign clr_wr = bus_wr && (bus_addr == OFS_STATUS) && bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_q  <= CAL_RESET;
            ctrl_q <= 1'b0;
        end else begin
            if (cal_wr) cal_q <= bus_wdata[CAL_W-1:0];
            if (bus_wr && bus_addr == OFS_CONTROL) ctrl_q <= bus_wdata[DATA_W-1];
        end
    end

    // a tick outranks a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (tick)   flag_q <= 1'b1;
        else if (clr_wr) flag_q <= 1'b0;
    end

    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            OFS_SET_RD:  rd_mux = set_time;
            OFS_CAL:     rd_mux = DATA_W'(cal_q);
            OFS_NOW:     rd_mux = cur_time;
            OFS_STATUS:  rd_mux = DATA_W'(flag_q);
            OFS_CONTROL: rd_mux = {ctrl_q, {(DATA_W-1){1'b0}}};
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign cnt_max = cal_q[CNT_W-1:0];
    assign frac    = cal_q[FRAC_LSB +: FRAC_W];
    assign frac_en = cal_q[EN_BIT];
    assign irq     = flag_q;

    // R9: every tick sets the flag
    a_r9_tick_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> flag_q);

    // R9: the flag is sticky without a write of 1
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_wr) |=> flag_q);

    // R9: the flag rises only on a tick
    a_r9_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(tick));

endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core
    import rtc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sec_irq
);

    logic              tick;
    logic              set_wr;
    logic              cal_wr;
    logic [CNT_W-1:0]  cnt_max;
    logic [FRAC_W-1:0] frac;
    logic              frac_en;
    logic [DATA_W-1:0] cur_time;
    logic [DATA_W-1:0] set_time;

    rtc_regs #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick      (tick),
        .cur_time  (cur_time),
        .set_time  (set_time),
        .set_wr    (set_wr),
        .cal_wr    (cal_wr),
        .cnt_max   (cnt_max),
        .frac      (frac),
        .frac_en   (frac_en),
        .irq       (sec_irq)
    );

    rtc_tick_div #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cal_wr),
        .cnt_max (cnt_max),
        .frac    (frac),
        .frac_en (frac_en),
        .tick    (tick)
    );

    rtc_time_keeper #(.TIME_W(DATA_W)) u_keep (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .set_wr   (set_wr),
        .set_data (bus_wdata),
        .cur_time (cur_time),
        .set_time (set_time)
    );

    // R10: the pin can only rise after a tick
    a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec_irq) |-> $past(tick));

endmodule

// File: tb/sim_rtc_sec_core.sv
module sim_rtc_sec_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sec_irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    rtc_sec_core u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .sec_irq(sec_irq)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard as read data appears
    always begin
        @(posedge clk);
        if (bus_rd) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
                check("scoreboard empty", bus_rdata, 32'hx);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_tick(output int t);
        while (!sec_irq) @(negedge clk);
        t = cyc;
    endtask

    task automatic clear_flag();
        wr(8'h20, 32'h1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int w, t1, t2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq low", {31'b0, sec_irq}, 32'h0);
        rd(8'h10, 32'h0, "R1 current time");
        rd(8'h04, 32'h0, "R1 set readback");
        rd(8'h20, 32'h0, "R1 status");
        rd(8'h40, 32'h0, "R1 control");
        rd(8'h08, 32'h00198233, "R1 calibration");
        rd(8'h00, 32'h0, "R2 offset 0 reads 0");

        // R7 masking, R6 restart from a write
        wr(8'h08, 32'hFFE000C7);
        w = cyc;
        rd(8'h08, 32'h000000C7, "R7 calibration mask");
        wait_tick(t1);
        check("R6 first tick spacing", t1 - w, 200);
        check("R10 irq high after tick", {31'b0, sec_irq}, 32'h1);
        rd(8'h20, 32'h1, "R9 flag set");
        rd(8'h10, 32'h1, "R4 first increment");
        wr(8'h20, 32'h0);
        rd(8'h20, 32'h1, "R9 write 0 no effect");
        check("R10 irq still high", {31'b0, sec_irq}, 32'h1);
        clear_flag();
        rd(8'h20, 32'h0, "R9 cleared");
        check("R10 irq low after clear", {31'b0, sec_irq}, 32'h0);

        // R5 period
        wait_tick(t2);
        check("R5 tick period", t2 - t1, 200);
        clear_flag();
        rd(8'h10, 32'h2, "R4 second increment");

        // R2 / R3 deferred load
        wr(8'h00, 32'h12345678);
        rd(8'h04, 32'h12345678, "R2 readback");
        rd(8'h10, 32'h2, "R3 not yet visible");
        wait_tick(t1);
        clear_flag();
        rd(8'h10, 32'h12345678, "R3 loaded on tick");
        wait_tick(t1);
        clear_flag();
        rd(8'h10, 32'h12345679, "R4 increment after load");
        rd(8'h04, 32'h12345678, "R2 readback kept");

        // R3 last of several writes
        wr(8'h00, 32'hAAAA0000);
        wr(8'h00, 32'h00000100);
        rd(8'h10, 32'h12345679, "R3 held before tick");
        wait_tick(t1);
        clear_flag();
        rd(8'h10, 32'h00000100, "R3 last write loaded");

        // R11 control
        wr(8'h40, 32'hFFFFFFFF);
        rd(8'h40, 32'h80000000, "R11 only bit 31");
        wr(8'h40, 32'h0);
        rd(8'h40, 32'h0, "R11 cleared");

        // R6 restart mid-second
        wait_tick(t1);
        clear_flag();
        repeat (50) @(negedge clk);
        wr(8'h08, 32'h000000C7);
        w = cyc;
        wait_tick(t2);
        clear_flag();
        check("R6 mid-second restart", t2 - w, 200);

        // R8 fractional trim, F=5
        wr(8'h08, 32'h001500C7);
        w = cyc;
        rd(8'h08, 32'h001500C7, "R7 fraction fields kept");
        for (int k = 0; k < 16; k++) begin
            wait_tick(t2);
            clear_flag();
        end
        check("R8 sixteen-second span", t2 - w, 16 * 200 + 5);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule